// File: doc/BRIEF.md
# Control-Transfer Instruction Translator

This block rewrites one 32-bit RISC-V control-transfer instruction into its ARM equivalent, one instruction per clock. A branch-if-equal or branch-if-greater-or-equal becomes a pair of ARM words: a flag-setting compare of the two source registers, then a conditional branch whose offset field is left at zero. A later pass of the surrounding translator fills in that offset. A register jump of the form `jalr x0, 0(rs)` becomes one branch-exchange word. Every other encoding is flagged as unsupported.

The block also exposes the RISC-V branch immediate, reassembled from its split fields and sign-extended to 32 bits. The offset-patching logic outside the block uses it to locate branch targets. RISC-V register numbers are renamed to 4-bit ARM register numbers through a fixed lookup held inside the block. All outputs are registered, so each result appears one clock after its instruction is presented.

Top module: `ctl_xlate`

## Requirements
- R1: All outputs are registered. The result for the instruction sampled at a rising edge is visible after that edge. While `rst_n` is low at an edge, every output is cleared to zero, and that includes `illegal_o`.
- R2: An instruction with opcode bits[6:0] = 1100011 and funct3 bits[14:12] = 000 gives `count_o` = 2, `illegal_o` = 0, and `word1_o` = 0x0A000000 (condition 0000, bits 27:25 = 101, link bit 24 = 0, offset 0).
- R3: An instruction with opcode 1100011 and funct3 101 gives `count_o` = 2, `illegal_o` = 0, and `word1_o` = 0xAA000000 (condition 1010).
- R4: For both branches, `word0_o` = 0xE1500000 | (map(rs1) << 16) | map(rs2). Here rs1 is bits[19:15] and rs2 is bits[24:20]. This is condition 1110, register data-processing form, opcode 1010 in bits 24:21, status bit 20 = 1, and destination field 15:12 = 0.
- R5: An instruction with opcode 1100111, funct3 000, rd bits[11:7] = 0 and immediate bits[31:20] = 0 gives `count_o` = 1, `illegal_o` = 0, `word0_o` = 0xE12FFF10 | map(rs1), and `word1_o` = 0.
- R6: Any other encoding gives `count_o` = 0, `illegal_o` = 1, and both words 0. This covers other opcodes, other branch funct3 values, and a jump with nonzero rd, nonzero immediate or nonzero funct3.
- R7: `br_offset_o` is the 13-bit value {bit31, bit7, bits30:25, bits11:8, 0}, sign-extended from bit 12 to 32 bits. It is produced for every input, whatever the decode result.
- R8: The register map sends RISC-V register n to ARM register n mod 16. For example x0 maps to 0, x15 to 15, x16 to 0 and x31 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | RISC-V instruction to translate |
| word0_o | output | 32 | First ARM word (compare or branch-exchange) |
| word1_o | output | 32 | Second ARM word (conditional branch) or 0 |
| count_o | output | 2 | Number of valid ARM words: 0, 1 or 2 |
| illegal_o | output | 1 | Input is not a supported control transfer |
| br_offset_o | output | 32 | Sign-extended RISC-V branch immediate |

## Verification
Every output of this block is due exactly one rising edge after its instruction is sampled. The words, the count, the unsupported flag and the offset all share that one-register latency. The bench changes `instr_i` on a falling edge and compares all five outputs at the next falling edge against a behavioural model evaluated on the same instruction, so each comparison lands half a period after the capturing edge. Reset is checked the same way, with the outputs read one edge after `rst_n` was sampled low.

// File: rtl/ctl_xlate_pkg.sv
// Package: shared constants and types for the control-transfer translator.
// Assumes 32-bit instructions on both sides and 4-bit ARM register numbers.
package ctl_xlate_pkg;
    localparam int XLEN      = 32;
    localparam int SRC_REGS  = 32;
    localparam int DST_W     = 4;
    localparam int SRC_W     = $clog2(SRC_REGS);

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JUMPR  = 7'b1100111;
    localparam logic [2:0] F3_EQ      = 3'b000;
    localparam logic [2:0] F3_GE      = 3'b101;
    localparam logic [2:0] F3_JUMPR   = 3'b000;

    localparam logic [3:0] COND_ALWAYS = 4'b1110;
    localparam logic [3:0] COND_ZERO   = 4'b0000;
    localparam logic [3:0] COND_NEQV   = 4'b1010;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_EQ   = 2'd1,
        K_GE   = 2'd2,
        K_JUMP = 2'd3
    } ctl_kind_e;
endpackage

// File: rtl/ctl_reg_map.sv
// Module: fixed register renaming lookup, RISC-V number to ARM number.
// Assumes the table is filled with n mod 2**DST_W; purely combinational.
module ctl_reg_map #(
    parameter int SRC_REGS = 32,
    parameter int DST_W    = 4,
    localparam int SRC_W   = $clog2(SRC_REGS)
) (
    input  logic [SRC_W-1:0] src_i,
    output logic [DST_W-1:0] dst_o
);
    localparam int DST_REGS = 1 << DST_W;

    logic [DST_W-1:0] lut [SRC_REGS];

    // Fill one table entry per source register.
    for (genvar g = 0; g < SRC_REGS; g++) begin : g_entry
        localparam int VAL = g % DST_REGS;
        assign lut[g] = DST_W'(VAL);
    end

    // Read the entry for the requested register.
    assign dst_o = lut[src_i];
endmodule

// File: rtl/ctl_imm_extract.sv
// Module: reassembles the split branch immediate and sign-extends it.
// Assumes the standard conditional-branch bit layout; bit 0 is always zero.
module ctl_imm_extract #(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [XLEN-1:0] offset_o
);
    localparam int IMM_W = 13;

    logic [IMM_W-1:0] imm;

    // Gather the scattered immediate fields into one value.
    always_comb begin
        imm = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
    end

    // Replicate the sign bit up to the full width.
    assign offset_o = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
endmodule

// File: rtl/ctl_decode.sv
// Module: classifies an instruction as equal-branch, ge-branch, register jump or unsupported.
// Assumes the jump is accepted only with rd = 0, immediate 0 and funct3 000.
module ctl_decode
    import ctl_xlate_pkg::*;
(
    input  logic [31:0] instr_i,
    output ctl_kind_e   kind_o
);
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [4:0]  rd;
    logic [11:0] imm12;

    assign opc   = instr_i[6:0];
    assign f3    = instr_i[14:12];
    assign rd    = instr_i[11:7];
    assign imm12 = instr_i[31:20];

    // Pick the instruction kind from opcode and field constraints.
    always_comb begin
        kind_o = K_NONE;
        if (opc == OPC_BRANCH) begin
            if (f3 == F3_EQ)      kind_o = K_EQ;
            else if (f3 == F3_GE) kind_o = K_GE;
        end else if (opc == OPC_JUMPR) begin
            if (f3 == F3_JUMPR && rd == '0 && imm12 == '0) kind_o = K_JUMP;
        end
    end
endmodule

// File: rtl/ctl_word_build.sv
// Module: composes the ARM words and word count for a decoded kind.
// Assumes register numbers are already renamed; branch offset left at zero.
module ctl_word_build
    import ctl_xlate_pkg::*;
#(
    parameter int DST_W = 4
) (
    input  ctl_kind_e        kind_i,
    input  logic [DST_W-1:0] rn_i,
    input  logic [DST_W-1:0] rm_i,
    output logic [31:0]      word0_o,
    output logic [31:0]      word1_o,
    output logic [1:0]       count_o
);
    logic [31:0] cmp_word;
    logic [31:0] bx_word;

    // Compare: always, register form, opcode 1010, status set, Rd 0.
    assign cmp_word = {COND_ALWAYS, 2'b00, 1'b0, 4'b1010, 1'b1,
                       4'(rn_i), 4'b0000, 8'h00, 4'(rm_i)};
    // Branch-exchange: always, fixed pattern, target register low.
    assign bx_word  = {COND_ALWAYS, 24'h12FFF1, 4'(rm_i)};

    // Select output words per kind.
    always_comb begin
        word0_o = '0;
        word1_o = '0;
        count_o = 2'd0;
        case (kind_i)
            K_EQ: begin
                word0_o = cmp_word;
                word1_o = {COND_ZERO, 3'b101, 1'b0, 24'h0};
                count_o = 2'd2;
            end
            K_GE: begin
                word0_o = cmp_word;
                word1_o = {COND_NEQV, 3'b101, 1'b0, 24'h0};
                count_o = 2'd2;
            end
            K_JUMP: begin
                word0_o = bx_word;
                count_o = 2'd1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_xlate.sv
// Module: top of the control-transfer translator; one instruction per clock,
// all outputs registered. Assumes a synchronous active-low reset.
module ctl_xlate
    import ctl_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr_i,
    output logic [31:0] word0_o,
    output logic [31:0] word1_o,
    output logic [1:0]  count_o,
    output logic        illegal_o,
    output logic [31:0] br_offset_o
);
    ctl_kind_e        kind;
    logic [DST_W-1:0] rn_map;
    logic [DST_W-1:0] rm_map;
    logic [DST_W-1:0] jmp_map;
    logic [DST_W-1:0] second_reg;
    logic [31:0]      w0_n;
    logic [31:0]      w1_n;
    logic [1:0]       cnt_n;
    logic [XLEN-1:0]  off_n;

    ctl_decode u_decode (.instr_i(instr_i), .kind_o(kind));

    ctl_reg_map #(.SRC_REGS(SRC_REGS), .DST_W(DST_W)) u_map_rs1 (
        .src_i(instr_i[19:15]), .dst_o(rn_map));
    ctl_reg_map #(.SRC_REGS(SRC_REGS), .DST_W(DST_W)) u_map_rs2 (
        .src_i(instr_i[24:20]), .dst_o(rm_map));

    // The jump target sits in rs1 but lands in the low register field.
    assign jmp_map    = rn_map;
    assign second_reg = (kind == K_JUMP) ? jmp_map : rm_map;

    ctl_word_build #(.DST_W(DST_W)) u_build (
        .kind_i(kind), .rn_i(rn_map), .rm_i(second_reg),
        .word0_o(w0_n), .word1_o(w1_n), .count_o(cnt_n));

    ctl_imm_extract #(.XLEN(XLEN)) u_imm (.instr_i(instr_i), .offset_o(off_n));

    // Register every result, cleared under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0_o     <= '0;
            word1_o     <= '0;
            count_o     <= '0;
            illegal_o   <= 1'b0;
            br_offset_o <= '0;
        end else begin
            word0_o     <= w0_n;
            word1_o     <= w1_n;
            count_o     <= cnt_n;
            illegal_o   <= (kind == K_NONE);
            br_offset_o <= off_n;
        end
    end

    // R2: an equal-branch input yields a pair ending in a zero-condition branch.
    a_r2_eq_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[6:0]) == 7'b1100011 && $past(instr_i[14:12]) == 3'b000)
        |-> (count_o == 2'd2 && word1_o == 32'h0A000000));

    // R3: a ge-branch input yields a pair ending in an N-equals-V branch.
    a_r3_ge_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[6:0]) == 7'b1100011 && $past(instr_i[14:12]) == 3'b101)
        |-> (count_o == 2'd2 && word1_o == 32'hAA000000));

    // R4: every two-word result starts with a flag-setting compare, Rd 0.
    a_r4_cmp_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == 2'd2) |-> (word0_o[31:20] == 12'hE15 && word0_o[15:4] == 12'h000));

    // R5: a single-word result is a branch-exchange with nothing after it.
    a_r5_jump_single: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == 2'd1) |-> (word0_o[31:4] == 28'hE12FFF1 && word1_o == 32'h0));

    // R6: an unsupported input produces no words.
    a_r6_illegal_empty: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (count_o == 2'd0 && word0_o == 32'h0 && word1_o == 32'h0));

    // R7: the offset sign follows the top instruction bit of the cycle before.
    a_r7_offset_sign: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (br_offset_o[31] == $past(instr_i[31]) && br_offset_o[0] == 1'b0));
endmodule

// File: tb/test_ctl_xlate.sv
`timescale 1ns/1ps
module test_ctl_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] word0_o, word1_o, br_offset_o;
    logic [1:0]  count_o;
    logic        illegal_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl_xlate i_ctl_xlate (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
        .word0_o(word0_o), .word1_o(word1_o), .count_o(count_o),
        .illegal_o(illegal_o), .br_offset_o(br_offset_o));

    // Pending expectations, one entry per applied instruction.
    logic [31:0] q_instr[$];
    string       q_tag[$];

    function automatic int rmap(input int n);
        return n % 16;
    endfunction

    function automatic logic [31:0] enc_b(input int f3, input int rs1, input int rs2, input int off);
        logic [12:0] im = 13'(off);
        return {im[12], im[10:5], 5'(rs2), 5'(rs1), 3'(f3), im[4:1], im[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(input int rd, input int rs1, input int imm, input int f3);
        return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), 7'b1100111};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: work out expected outputs from the requirements.
    task automatic compare(input logic [31:0] ins, input string tag);
        int opc = int'(ins[6:0]);
        int f3  = int'(ins[14:12]);
        int rd  = int'(ins[11:7]);
        int r1  = int'(ins[19:15]);
        int r2  = int'(ins[24:20]);
        int imm = int'(ins[31:20]);
        int off;
        logic [31:0] e0 = 0, e1 = 0;
        int ec = 0;
        off = (ins[31] ? -4096 : 0) + (ins[7] ? 2048 : 0) + int'(ins[30:25]) * 32 + int'(ins[11:8]) * 2;
        if (opc == 'h63 && (f3 == 0 || f3 == 5)) begin
            ec = 2;
            e0 = 32'hE1500000 + rmap(r1) * 65536 + rmap(r2);
            e1 = (f3 == 0) ? 32'h0A000000 : 32'hAA000000;
        end else if (opc == 'h67 && f3 == 0 && rd == 0 && imm == 0) begin
            ec = 1;
            e0 = 32'hE12FFF10 + rmap(r1);
        end
        check(tag, "word0", word0_o, e0);
        check(tag, "word1", word1_o, e1);
        check(tag, "count", 32'(count_o), 32'(ec));
        check(tag, "illegal", 32'(illegal_o), 32'(ec == 0));
        check({tag, "/R7"}, "offset", br_offset_o, 32'(off));
    endtask

    // Present one instruction per cycle; compare the previous one each cycle.
    task automatic apply(input logic [31:0] ins, input string tag);
        @(negedge clk);
        if (q_instr.size() > 0) compare(q_instr.pop_front(), q_tag.pop_front());
        instr_i = ins;
        q_instr.push_back(ins);
        q_tag.push_back(tag);
    endtask

    task automatic drain();
        @(negedge clk);
        if (q_instr.size() > 0) compare(q_instr.pop_front(), q_tag.pop_front());
    endtask

    initial begin
        // R1: reset clears outputs even with a valid branch on the input.
        instr_i = enc_b(0, 5, 6, 8);
        repeat (3) @(negedge clk);
        check("R1", "reset word0", word0_o, 32'h0);
        check("R1", "reset word1", word1_o, 32'h0);
        check("R1", "reset count", 32'(count_o), 32'h0);
        check("R1", "reset illegal", 32'(illegal_o), 32'h0);
        check("R1", "reset offset", br_offset_o, 32'h0);
        rst_n = 1'b1;

        apply(enc_b(0, 5, 6, 8), "R2/R4 beq x5,x6");
        apply(enc_b(0, 17, 31, -4096), "R2/R8 beq x17,x31 min offset");
        apply(enc_b(5, 10, 3, 4094), "R3/R4 bge x10,x3 max offset");
        apply(enc_b(5, 15, 16, -2), "R3/R8 bge x15,x16");
        apply(enc_b(0, 0, 0, 0), "R2/R8 beq x0,x0");
        apply(enc_j(0, 1, 0, 0), "R5 jalr x1");
        apply(enc_j(0, 20, 0, 0), "R5/R8 jalr x20");
        apply(enc_j(1, 1, 0, 0), "R6 jalr rd!=0");
        apply(enc_j(0, 1, 4, 0), "R6 jalr imm!=0");
        apply(enc_j(0, 1, 0, 2), "R6 jalr funct3!=0");
        apply(enc_b(1, 4, 5, 16), "R6 bne unsupported");
        apply(32'h00B50533, "R6 alu opcode");
        apply(32'hFFFFFFFF, "R6 all ones");

        // R7 and mixed kinds: random stimulus across opcodes.
        for (int k = 0; k < 300; k++) begin
            logic [31:0] r = $urandom;
            case (k % 4)
                0: r[6:0] = 7'b1100011;
                1: begin r[6:0] = 7'b1100111; r[14:12] = 3'b000; r[11:7] = 5'd0; r[31:20] = 12'd0; end
                2: r[6:0] = 7'b1100111;
                default: ;
            endcase
            apply(r, "R2/R3/R5/R6/R7 random");
        end
        drain();

        // R1: reset asserted mid-stream clears on the next edge.
        instr_i = enc_b(5, 7, 8, 12);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid reset count", 32'(count_o), 32'h0);
        check("R1", "mid reset word0", word0_o, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule